// File: doc/BRIEF.md
# Partner-Set Line Balancing Tag Controller

This block is the tag side of a small set-associative cache. Every set is tied to one fixed partner set, whose index is the same except that the top index bit is inverted. Each set keeps a miss/hit pressure counter. When a busy set must evict a line, and its partner is lightly loaded, the line moves into the partner instead of leaving the cache. A moved line carries a guest flag, and the home set carries a lent flag while the partner still holds any of its guests. A lookup that misses at home probes the partner only when the home set's lent flag is up. This keeps the usual single-set tag read on most accesses.

A request is one line address, `{tag, index}`, with the index in the low bits. The controller takes one request at a time. It answers with hit or miss and the set and way involved, which is the fill location on a miss. On a miss it allocates the line at once. If a line has to leave the cache, it reports that line's full address. The data array and the next memory level belong to the surrounding logic.

Top module: `pairbal_tag_ctrl`

## Requirements
- R1: After reset, all lines are invalid, all pressure counters are 0, and all lent flags are clear. `req_ready_o` is 1, and `resp_valid_o` and `evict_valid_o` are 0.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` stays 0 until the response is issued. If the lookup is resolved in the home set, `resp_valid_o` is 1 for one cycle, starting one edge after the accept edge.
- R3: On a home miss, the partner set (index XOR SETS/2) is probed only when the home set's lent flag is 1. This adds exactly one cycle. A hit there reports `resp_set_o` equal to the partner index.
- R4: A home probe matches only lines whose guest flag is 0. A partner probe matches only lines whose guest flag is 1. So an equal tag that belongs to the other set's own address never hits.
- R5: On a final miss, the tag is written into the home set's LRU way with guest flag 0 and becomes MRU. The response reports hit 0 and that set and way. A set that has never been filled uses way WAYS-1 first, then the ways in descending order.
- R6: Each set keeps true LRU order over its ways. Every hit or write moves the touched way to MRU.
- R7: Each set's pressure counter ranges over 0..2*WAYS-1. It rises by 1 on a final miss and falls by 1 on a final hit, once per request, and it saturates at both ends.
- R8: On a final miss, the home victim migrates if, before the request, the home counter equals 2*WAYS-1, the partner counter is below WAYS, and the victim is valid with guest flag 0. The victim then takes the partner's LRU way with guest flag 1 and becomes MRU there. The partner's old LRU line, if valid, is the one reported evicted. Otherwise, a valid victim is reported evicted.
- R9: `evict_addr_o` is `{tag, index}` of the departing line. For a guest line, the index is its owner's index, which is the index of the set holding it XOR SETS/2.
- R10: A set's lent flag is set by a migration out of it. It is cleared once its partner holds no valid guest lines. After that, home misses take no partner probe cycle.
- R11: A line found in the partner stays in the partner set. A repeated lookup of it hits in the partner again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_addr_i | input | TAG_W+log2(SETS) | Line address `{tag, index}` |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| resp_valid_o | output | 1 | Response valid for one cycle |
| resp_hit_o | output | 1 | 1 = hit, 0 = miss (line allocated) |
| resp_set_o | output | log2(SETS) | Set of the hit line or of the fill |
| resp_way_o | output | log2(WAYS) | Way of the hit line or of the fill |
| evict_valid_o | output | 1 | A valid line left the cache with this response |
| evict_addr_o | output | TAG_W+log2(SETS) | Address of the line that left |

## Verification
The hardest state to reach from the ports is a migration. It needs one set driven to full pressure by eight straight misses, while its partner stays below half pressure. After that come the rarer cases: a partner hit, a guest line being pushed out of the partner with its owner's address, and the lent flag clearing. The stimulus first walks through that exact sequence on sets 0 and 4. It then runs long pseudo-random streams whose indices are biased first toward one half of the sets and then toward the other, so migrations happen in both directions. A reference model in the bench predicts every response, eviction and latency.

// File: rtl/pairbal_pkg.sv
package pairbal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOME = 2'd1,
    ST_PART = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/pairbal_sat_ctr.sv
module pairbal_sat_ctr #(
  parameter int MAXV = 7,
  localparam int CW = $clog2(MAXV + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != CW'(MAXV)) cnt_q <= cnt_q + CW'(1);
    else if (dec_i && !inc_i && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign cnt_o = cnt_q;

  a_r7_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && cnt_o != CW'(MAXV)) |=> cnt_o == $past(cnt_o) + CW'(1));
  a_r7_hold_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_o == CW'(MAXV)) |=> cnt_o == CW'(MAXV));
  a_r7_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && cnt_o == '0) |=> cnt_o == '0);
endmodule

// File: rtl/pairbal_tag_set.sv
module pairbal_tag_set #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] cmp_tag_i,
  input  logic             cmp_guest_i,
  input  logic             upd_en_i,
  input  logic             upd_wr_i,
  input  logic [WAY_W-1:0] upd_way_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  input  logic             upd_guest_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [WAY_W-1:0] lru_way_o,
  output logic             lru_valid_o,
  output logic [TAG_W-1:0] lru_tag_o,
  output logic             lru_guest_o,
  output logic             any_guest_o
);
  logic [WAYS-1:0]  vld_q;
  logic [WAYS-1:0]  guest_q;
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [WAY_W-1:0] age_q [WAYS];
  logic [WAYS-1:0]  match;
  logic [WAYS-1:0]  is_lru;

  always_comb begin
    hit_way_o = '0;
    lru_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      match[w]  = vld_q[w] && (tag_q[w] == cmp_tag_i) && (guest_q[w] == cmp_guest_i);
      is_lru[w] = (age_q[w] == WAY_W'(WAYS - 1));
      if (match[w])  hit_way_o = WAY_W'(w);
      if (is_lru[w]) lru_way_o = WAY_W'(w);
    end
    hit_o       = |match;
    lru_valid_o = vld_q[lru_way_o];
    lru_tag_o   = tag_q[lru_way_o];
    lru_guest_o = guest_q[lru_way_o];
    any_guest_o = |(guest_q & vld_q);
  end

  // age 0 = MRU; reset ranks give way WAYS-1 as first victim
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      guest_q <= '0;
      for (int w = 0; w < WAYS; w++) begin
        tag_q[w] <= '0;
        age_q[w] <= WAY_W'(w);
      end
    end else if (upd_en_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (upd_way_i == WAY_W'(w)) begin
          age_q[w] <= '0;
          if (upd_wr_i) begin
            vld_q[w]   <= 1'b1;
            tag_q[w]   <= upd_tag_i;
            guest_q[w] <= upd_guest_i;
          end
        end else if (age_q[w] < age_q[upd_way_i]) begin
          age_q[w] <= age_q[w] + WAY_W'(1);
        end
      end
    end
  end

  a_r6_single_lru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(is_lru) == 1);
  a_r4_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
  a_r6_touch_mru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> age_q[$past(upd_way_i)] == '0);
  a_r5_write_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_wr_i) |=> vld_q[$past(upd_way_i)]);
endmodule

// File: rtl/pairbal_tag_ctrl.sv
module pairbal_tag_ctrl
  import pairbal_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int TAG_W = 8,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [IDX_W-1:0]  resp_set_o,
  output logic [WAY_W-1:0]  resp_way_o,
  output logic              evict_valid_o,
  output logic [ADDR_W-1:0] evict_addr_o
);
  localparam int CTR_MAX = 2 * WAYS - 1;
  localparam int CTR_W   = $clog2(CTR_MAX + 1);
  localparam int HALF    = SETS / 2;
  localparam logic [IDX_W-1:0] PART_MASK = IDX_W'(HALF);

  ctrl_state_e      state_q;
  logic [TAG_W-1:0] q_tag;
  logic [IDX_W-1:0] q_idx, part_idx;
  logic [SETS-1:0]  lent_q;

  logic [SETS-1:0]  set_hit, set_lru_valid, set_lru_guest, set_any_guest;
  logic [WAY_W-1:0] set_hit_way [SETS];
  logic [WAY_W-1:0] set_lru_way [SETS];
  logic [TAG_W-1:0] set_lru_tag [SETS];
  logic [SETS-1:0]  upd_en, upd_wr, upd_guest;
  logic [WAY_W-1:0] upd_way [SETS];
  logic [TAG_W-1:0] upd_tag [SETS];
  logic [SETS-1:0]  ctr_inc, ctr_dec, lent_set;
  logic [CTR_W-1:0] ctr_val [SETS];

  logic             finish, fin_hit, in_part, migrate;
  logic [IDX_W-1:0] hit_set;
  logic [WAY_W-1:0] hit_way;
  logic             ev_v;
  logic [ADDR_W-1:0] ev_addr;

  assign part_idx    = q_idx ^ PART_MASK;
  assign req_ready_o = (state_q == ST_IDLE);

  for (genvar s = 0; s < SETS; s++) begin : g_set
    localparam logic UPPER = (s >= HALF);
    pairbal_tag_set #(.WAYS(WAYS), .TAG_W(TAG_W)) u_set (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmp_tag_i   (q_tag),
      .cmp_guest_i (q_idx[IDX_W-1] != UPPER),
      .upd_en_i    (upd_en[s]),
      .upd_wr_i    (upd_wr[s]),
      .upd_way_i   (upd_way[s]),
      .upd_tag_i   (upd_tag[s]),
      .upd_guest_i (upd_guest[s]),
      .hit_o       (set_hit[s]),
      .hit_way_o   (set_hit_way[s]),
      .lru_way_o   (set_lru_way[s]),
      .lru_valid_o (set_lru_valid[s]),
      .lru_tag_o   (set_lru_tag[s]),
      .lru_guest_o (set_lru_guest[s]),
      .any_guest_o (set_any_guest[s])
    );
    pairbal_sat_ctr #(.MAXV(CTR_MAX)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (ctr_inc[s]),
      .dec_i  (ctr_dec[s]),
      .cnt_o  (ctr_val[s])
    );
  end

  always_comb begin
    in_part = (state_q == ST_PART);
    finish  = 1'b0;
    fin_hit = 1'b0;
    unique case (state_q)
      ST_HOME: begin
        finish  = set_hit[q_idx] | ~lent_q[q_idx];
        fin_hit = set_hit[q_idx];
      end
      ST_PART: begin
        finish  = 1'b1;
        fin_hit = set_hit[part_idx];
      end
      default: ;
    endcase
    hit_set = in_part ? part_idx : q_idx;
    hit_way = in_part ? set_hit_way[part_idx] : set_hit_way[q_idx];

    // decision uses counters as they stood before this request
    migrate = finish && !fin_hit
           && (ctr_val[q_idx] == CTR_W'(CTR_MAX))
           && (ctr_val[part_idx] < CTR_W'(WAYS))
           && set_lru_valid[q_idx] && !set_lru_guest[q_idx];

    if (migrate) begin
      ev_v    = set_lru_valid[part_idx];
      ev_addr = {set_lru_tag[part_idx], set_lru_guest[part_idx] ? q_idx : part_idx};
    end else begin
      ev_v    = finish && !fin_hit && set_lru_valid[q_idx];
      ev_addr = {set_lru_tag[q_idx], set_lru_guest[q_idx] ? part_idx : q_idx};
    end
  end

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      upd_en[s]    = 1'b0;
      upd_wr[s]    = 1'b0;
      upd_guest[s] = 1'b0;
      upd_way[s]   = '0;
      upd_tag[s]   = '0;
      ctr_inc[s]   = finish && !fin_hit && (q_idx == IDX_W'(s));
      ctr_dec[s]   = finish && fin_hit && (q_idx == IDX_W'(s));
      lent_set[s]  = migrate && (q_idx == IDX_W'(s));
      if (finish) begin
        if (fin_hit) begin
          if (hit_set == IDX_W'(s)) begin
            upd_en[s]  = 1'b1;
            upd_way[s] = hit_way;
          end
        end else if (q_idx == IDX_W'(s)) begin
          upd_en[s]  = 1'b1;
          upd_wr[s]  = 1'b1;
          upd_way[s] = set_lru_way[q_idx];
          upd_tag[s] = q_tag;
        end else if (migrate && part_idx == IDX_W'(s)) begin
          upd_en[s]    = 1'b1;
          upd_wr[s]    = 1'b1;
          upd_guest[s] = 1'b1;
          upd_way[s]   = set_lru_way[part_idx];
          upd_tag[s]   = set_lru_tag[q_idx];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lent_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++)
        lent_q[s] <= lent_set[s] | (lent_q[s] & set_any_guest[s ^ HALF]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      q_tag         <= '0;
      q_idx         <= '0;
      resp_valid_o  <= 1'b0;
      resp_hit_o    <= 1'b0;
      resp_set_o    <= '0;
      resp_way_o    <= '0;
      evict_valid_o <= 1'b0;
      evict_addr_o  <= '0;
    end else begin
      resp_valid_o  <= finish;
      resp_hit_o    <= finish && fin_hit;
      evict_valid_o <= ev_v;
      if (finish) begin
        resp_set_o   <= fin_hit ? hit_set : q_idx;
        resp_way_o   <= fin_hit ? hit_way : set_lru_way[q_idx];
        evict_addr_o <= ev_addr;
      end
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q <= ST_HOME;
          q_tag   <= req_addr_i[ADDR_W-1:IDX_W];
          q_idx   <= req_addr_i[IDX_W-1:0];
        end
        ST_HOME: state_q <= finish ? ST_IDLE : ST_PART;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r3_probe_needs_lent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PART) |-> $past(lent_q[q_idx]));
  a_r10_lent_after_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    migrate |=> lent_q[$past(q_idx)]);
  a_r8_evict_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> (resp_valid_o && !resp_hit_o));
endmodule

// File: tb/sim_pairbal_tag_ctrl.sv
`timescale 1ns/1ps
module sim_pairbal_tag_ctrl;
  localparam int WAYS = 4, SETS = 8, TAG_W = 8;
  localparam int IDX_W = 3, WAY_W = 2, ADDR_W = TAG_W + IDX_W;
  localparam int CMAX = 2 * WAYS - 1, HALF = SETS / 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready_o, resp_valid_o, resp_hit_o, evict_valid_o;
  logic [IDX_W-1:0] resp_set_o;
  logic [WAY_W-1:0] resp_way_o;
  logic [ADDR_W-1:0] evict_addr_o;

  always #10 clk = ~clk;

  pairbal_tag_ctrl #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_ready_o(req_ready_o), .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o),
    .resp_set_o(resp_set_o), .resp_way_o(resp_way_o),
    .evict_valid_o(evict_valid_o), .evict_addr_o(evict_addr_o));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit hit; int set; int way; bit ev_v; int ev_addr; int lat; int acc;
  } exp_t;
  exp_t exp_q[$];

  bit m_v   [SETS][WAYS];
  bit m_g   [SETS][WAYS];
  int m_tag [SETS][WAYS];
  int m_ord [SETS][WAYS];   // [0] = MRU way
  int m_ctr [SETS];

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  function automatic int m_find(int s, int t, bit g);
    for (int w = 0; w < WAYS; w++)
      if (m_v[s][w] && m_tag[s][w] == t && m_g[s][w] == g) return w;
    return -1;
  endfunction

  function automatic void m_touch(int s, int w);
    int pos = 0;
    for (int k = 0; k < WAYS; k++) if (m_ord[s][k] == w) pos = k;
    for (int k = pos; k > 0; k--) m_ord[s][k] = m_ord[s][k-1];
    m_ord[s][0] = w;
  endfunction

  function automatic bit m_anyg(int s);
    for (int w = 0; w < WAYS; w++) if (m_v[s][w] && m_g[s][w]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic do_req(int t, int h);
    exp_t e;
    int p, w, v, pv;
    bit found, mig;
    p = h ^ HALF;
    e.ev_v = 0; e.ev_addr = 0; e.lat = 1; found = 0;
    w = m_find(h, t, 1'b0);
    if (w >= 0) begin
      found = 1; e.hit = 1; e.set = h; e.way = w; m_touch(h, w);
    end else if (m_anyg(p)) begin
      e.lat = 2;
      w = m_find(p, t, 1'b1);
      if (w >= 0) begin
        found = 1; e.hit = 1; e.set = p; e.way = w; m_touch(p, w);
      end
    end
    if (!found) begin
      v   = m_ord[h][WAYS-1];
      mig = (m_ctr[h] == CMAX) && (m_ctr[p] < WAYS) && m_v[h][v] && !m_g[h][v];
      if (mig) begin
        pv = m_ord[p][WAYS-1];
        e.ev_v = m_v[p][pv];
        e.ev_addr = (m_tag[p][pv] << IDX_W) | (m_g[p][pv] ? h : p);
        m_v[p][pv] = 1; m_tag[p][pv] = m_tag[h][v]; m_g[p][pv] = 1; m_touch(p, pv);
      end else begin
        e.ev_v = m_v[h][v];
        e.ev_addr = (m_tag[h][v] << IDX_W) | (m_g[h][v] ? p : h);
      end
      m_v[h][v] = 1; m_tag[h][v] = t; m_g[h][v] = 0; m_touch(h, v);
      e.hit = 0; e.set = h; e.way = v;
    end
    if (e.hit) begin if (m_ctr[h] > 0) m_ctr[h]--; end
    else if (m_ctr[h] < CMAX) m_ctr[h]++;

    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    e.acc = cyc + 1;
    exp_q.push_back(e);
    req_valid = 1'b1;
    req_addr  = ADDR_W'((t << IDX_W) | h);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready_o == 1'b0, "R2", "ready while busy", int'(req_ready_o), 0);
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    exp_t e;
    if (rst_ni && resp_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected response", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk(resp_hit_o == e.hit, "R2/R3/R4/R11", "hit", int'(resp_hit_o), int'(e.hit));
        chk(int'(resp_set_o) == e.set, "R3/R5", "set", int'(resp_set_o), e.set);
        chk(int'(resp_way_o) == e.way, "R5/R6", "way", int'(resp_way_o), e.way);
        chk(evict_valid_o == e.ev_v, "R7/R8", "evict valid", int'(evict_valid_o), int'(e.ev_v));
        if (e.ev_v)
          chk(int'(evict_addr_o) == e.ev_addr, "R8/R9", "evict addr", int'(evict_addr_o), e.ev_addr);
        chk(cyc - e.acc == e.lat, "R3/R10", "latency", cyc - e.acc, e.lat);
      end
    end else if (rst_ni && evict_valid_o) begin
      chk(1'b0, "R8", "evict without response", 1, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    int t, h;
    lf = 16'hACE1;
    for (int s = 0; s < SETS; s++) begin
      m_ctr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        m_v[s][w] = 0; m_g[s][w] = 0; m_tag[s][w] = 0; m_ord[s][w] = w;
      end
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R1", "ready after reset", int'(req_ready_o), 1);
    chk(resp_valid_o == 1'b0, "R1", "resp after reset", int'(resp_valid_o), 0);
    chk(evict_valid_o == 1'b0, "R1", "evict after reset", int'(evict_valid_o), 0);

    // R5 R6: fill order and LRU choice in set 1
    do_req(1, 1); do_req(2, 1); do_req(3, 1); do_req(4, 1);
    do_req(1, 1); do_req(3, 1);
    do_req(5, 1);
    do_req(2, 1);

    // R7 R8: eight misses saturate set 0, last one migrates into set 4
    for (int k = 0; k < 8; k++) do_req(16 + k, 0);
    do_req(19, 0);          // R3 partner hit
    do_req(19, 0);          // R11 stays in partner
    do_req(19, 4);          // R4 same tag, other owner: miss
    do_req(40, 0);          // R3 miss with partner probe
    // R9 R10: push guest lines out of set 4
    for (int k = 0; k < 6; k++) do_req(60 + k, 4);
    do_req(41, 0);

    // pseudo-random traffic, skewed one way then the other
    for (int ph = 0; ph < 2; ph++) begin
      for (int n = 0; n < 300; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        h = int'(lf[0]);
        if ((lf[3:2] != 2'b00) == (ph == 1)) h = h + HALF;
        t = int'(lf[11:6]) % 10;
        do_req(t, h);
      end
    end

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "responses outstanding", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule